// File: doc/BRIEF.md
# DVMA Page-Table Translation Engine

This block converts a device-virtual transfer (start address, byte length, direction) into a stream of physical chunks. Each chunk covers at most one 4 KB page. For every page it touches, the engine reads one 32-bit page table entry through a request/acknowledge read port. It then checks the entry's valid flag, and for writes also its write-permission flag. Finally it emits the physical address and byte count of that piece.

A bus-master front end pulses `start` with the transfer parameters. It then consumes one `chunk_valid` pulse per page and waits for `done` or `abort`. The table base and the window start are sampled with `start`. The window start marks the high address bits that select the translation window; these bits are cleared before the page index is formed.

Top module: `dvma_xlate`

## Requirements
- R1: After reset the engine is idle: `busy`, `mem_req`, `chunk_valid`, `done` and `abort` are all low.
- R2: The entry read address is `(tbl_base << 4) + (((va & ~win_base) >> 10) & ~3)`, where `va` is the device-virtual address of the current chunk. The address is truncated to 32 bits, giving one 4-byte entry per 4 KB page.
- R3: The read port delivers the entry's byte at the lowest address on `mem_rdata[7:0]`. The entry value is big-endian, so the engine uses `{rdata[7:0], rdata[15:8], rdata[23:16], rdata[31:24]}`.
- R4: The chunk physical address is `((entry & 32'h07FFFF00) << 4) + va[11:0]`.
- R5: The chunk length is the smaller of the remaining byte count and the bytes left in the current 4 KB page (`4096 - va[11:0]`). The next chunk starts at `va` plus that length.
- R6: One entry fetch is made per chunk. `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen.
- R7: If an entry's valid flag (bit 1) is clear, no chunk is emitted for it. `abort` pulses for one cycle, no further fetch follows, and the engine returns to idle.
- R8: For a write, an entry whose write-permission flag (bit 2) is clear aborts the transfer in the same way as R7. A read is not affected by bit 2.
- R9: A start with zero length raises `done` in the next cycle and makes no fetch.
- R10: `chunk_valid` is a one-cycle pulse. `done` pulses in the cycle after the last chunk's pulse, and never together with `abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer; honoured only while idle |
| tbl_base | input | 32 | Page table base register |
| win_base | input | 32 | Translation window start; its set bits are cleared from addresses |
| dva | input | 32 | Device-virtual start address |
| xfer_len | input | LW | Transfer length in bytes |
| is_write | input | 1 | Transfer direction, 1 = write |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 32 | Entry read address |
| mem_ack | input | 1 | Read acknowledge; `mem_rdata` valid with it |
| mem_rdata | input | 32 | Entry bytes, lowest address in bits 7:0 |
| chunk_valid | output | 1 | One-cycle chunk strobe |
| chunk_pa | output | 32 | Chunk physical address |
| chunk_len | output | LW | Chunk byte count |
| done | output | 1 | Transfer completed |
| abort | output | 1 | Transfer aborted on an entry check |
| busy | output | 1 | Engine not idle |

## Verification
The bench targets transfers that end exactly on a page boundary, transfers that start one byte before a boundary, single-byte transfers and zero-length starts. A design with an off-by-one length rule would emit an empty or overlong chunk, or fetch an extra entry. Entries are generated with random upper and spare flag bits, so a design that masked the frame number wrongly, used the wrong byte order or shifted the index by the wrong amount produces wrong physical or entry addresses. Fault tables cover several cases: valid-but-read-only entries under both directions, and invalid entries appearing part-way through a multi-page transfer. In these, a faulty design would either emit a chunk for a bad page, keep fetching after the fault, or abort a legal read.

// File: rtl/dvma_xlate.sv
module dvma_xlate #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   tbl_base,
  input  logic [31:0]   win_base,
  input  logic [31:0]   dva,
  input  logic [LW-1:0] xfer_len,
  input  logic          is_write,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          chunk_valid,
  output logic [31:0]   chunk_pa,
  output logic [LW-1:0] chunk_len,
  output logic          done,
  output logic          abort,
  output logic          busy
);
  localparam int          PG      = 12;
  localparam logic [31:0] FRAME_M = 32'h07FF_FF00;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_CHECK, S_EMIT} st_t;

  st_t           st;
  logic [31:0]   va, base_q, win_q, ent;
  logic [LW-1:0] rem, room;
  logic          wr, done_q, abort_q;

  assign room      = LW'(1 << PG) - LW'(va[PG-1:0]);
  assign chunk_len = (rem < room) ? rem : room;
  assign chunk_pa  = ((ent & FRAME_M) << 4) + {{(32-PG){1'b0}}, va[PG-1:0]};
  assign mem_addr  = (base_q << 4) + (((va & ~win_q) >> 10) & ~32'd3);

  assign mem_req     = (st == S_FETCH);
  assign chunk_valid = (st == S_EMIT);
  assign busy        = (st != S_IDLE);
  assign done        = done_q;
  assign abort       = abort_q;

  wire ent_ok = ent[1] && (!wr || ent[2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va      <= '0;
      rem     <= '0;
      wr      <= 1'b0;
      base_q  <= '0;
      win_q   <= '0;
      ent     <= '0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            if (xfer_len == '0) begin
              done_q <= 1'b1;
            end else begin
              va     <= dva;
              rem    <= xfer_len;
              wr     <= is_write;
              base_q <= tbl_base;
              win_q  <= win_base;
              st     <= S_FETCH;
            end
          end
        S_FETCH:
          if (mem_ack) begin
            ent <= {mem_rdata[7:0], mem_rdata[15:8], mem_rdata[23:16], mem_rdata[31:24]};
            st  <= S_CHECK;
          end
        S_CHECK:
          if (ent_ok) st <= S_EMIT;
          else begin
            abort_q <= 1'b1;
            st      <= S_IDLE;
          end
        default: begin
          va  <= va + 32'(chunk_len);
          rem <= rem - chunk_len;
          if (rem == chunk_len) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= S_FETCH;
          end
        end
      endcase
    end
  end

  p_idle_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !busy && !done && !abort);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  p_chunk_in_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |-> (chunk_len != '0) &&
      ({1'b0, chunk_pa[PG-1:0]} + (PG+1)'(chunk_len) <= (PG+1)'(1 << PG)));

  p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && xfer_len == '0 |=> done && !mem_req);

  p_abort_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !mem_req && !chunk_valid && !done);

  p_chunk_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |=> !chunk_valid);
endmodule

// File: tb/tb_dvma_xlate.sv
`timescale 1ns/1ps
module tb_dvma_xlate;
  localparam int LW = 16;

  logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0, is_write = 1'b0;
  logic [31:0]   tbl_base = '0, win_base = '0, dva = '0, mem_rdata = '0;
  logic [LW-1:0] xfer_len = '0;
  logic          mem_ack = 1'b0;
  logic          mem_req, chunk_valid, done, abort, busy;
  logic [31:0]   mem_addr, chunk_pa;
  logic [LW-1:0] chunk_len;

  int checks = 0, errors = 0, mode = 0;

  always #5 clk = ~clk;

  dvma_xlate #(.LW(LW)) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mix(input logic [31:0] x);
    logic [31:0] h = x * 32'h9E37_79B1;
    return h ^ (h >> 15) ^ 32'h5A5A_1234;
  endfunction

  // R7 R8: flag bit 1 = valid, bit 2 = write permission
  function automatic logic [31:0] pte_at(input logic [31:0] ea);
    logic [31:0] h = mix(ea);
    logic v, w;
    case (mode)
      0: begin v = 1'b1; w = 1'b1; end
      1: begin v = h[20] | h[21] | h[23]; w = h[22]; end
      2: begin v = 1'b1; w = 1'b0; end
      default: begin v = 1'b0; w = 1'b0; end
    endcase
    return (h & 32'hFFFF_FFF9) | {29'b0, w, v, 1'b0};
  endfunction

  function automatic logic [31:0] swap(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [31:0] exp_ea(input logic [31:0] b, input logic [31:0] w, input logic [31:0] a);
    return (b << 4) + (((a & ~w) >> 10) & ~32'd3);
  endfunction

  task automatic run_xfer(input logic [31:0] b, input logic [31:0] w, input logic [31:0] a0,
                          input int len, input bit wr);
    logic [31:0] a, ea, e;
    int r, el, wait_n, guard;
    bit exp_abort, finished;
    tbl_base = b; win_base = w; dva = a0; xfer_len = LW'(len); is_write = wr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (len == 0) begin
      chk(done === 1'b1 && mem_req === 1'b0 && abort === 1'b0, "R9 zero-length done", {30'b0, done, mem_req}, 32'h2);
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, "R9 done one pulse", {30'b0, done, busy}, 32'h0);
      return;
    end
    a = a0; r = len; e = '0; exp_abort = 1'b0; finished = 1'b0; guard = 0; wait_n = $urandom % 3;
    while (!finished && guard < 40000) begin
      guard++;
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (exp_abort) chk(1'b0, "R7 fetch after fault", mem_addr, 32'h0);
        if (wait_n == 0) begin
          ea = exp_ea(b, w, a);
          chk(mem_addr === ea, "R2 entry address", mem_addr, ea);
          e = pte_at(ea);
          mem_rdata = swap(e);
          mem_ack = 1'b1;
          exp_abort = !e[1] || (wr && !e[2]);
          wait_n = $urandom % 3;
        end else wait_n--;
      end
      if (chunk_valid) begin
        if (exp_abort) chk(1'b0, wr ? "R8 chunk on unwritable entry" : "R7 chunk on invalid entry", chunk_pa, e);
        el = (r < 4096 - int'(a[11:0])) ? r : 4096 - int'(a[11:0]);
        chk(chunk_len === LW'(el), "R5 chunk length", 32'(chunk_len), el);
        chk(chunk_pa === ((e & 32'h07FF_FF00) << 4) + {20'b0, a[11:0]}, "R3 R4 physical address",
            chunk_pa, ((e & 32'h07FF_FF00) << 4) + {20'b0, a[11:0]});
        a = a + el; r = r - el;
      end
      if (abort) begin
        chk(exp_abort && done === 1'b0, wr ? "R8 abort" : "R7 abort", {31'b0, abort}, {31'b0, exp_abort});
        finished = 1'b1;
      end else if (done) begin
        chk(r == 0 && !exp_abort, "R10 done after last chunk", r, 0);
        finished = 1'b1;
      end
      if (!finished) @(negedge clk);
    end
    if (!finished) chk(1'b0, "R6 transfer hung", guard, 0);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && abort === 1'b0, "R10 return to idle", {31'b0, busy}, 32'h0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && mem_req === 1'b0 && chunk_valid === 1'b0 && done === 1'b0 && abort === 1'b0,
        "R1 reset state", {27'b0, busy, mem_req, chunk_valid, done, abort}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && mem_req === 1'b0, "R1 idle after reset", {30'b0, busy, mem_req}, 32'h0);

    mode = 0;
    run_xfer(32'h0012_3400, 32'hFF00_0000, 32'hFF00_0F00, 256, 1'b0);   // R5 ends on boundary
    run_xfer(32'h0012_3400, 32'hFF00_0000, 32'hFF00_1FFF, 2, 1'b1);     // R5 crosses by one byte
    run_xfer(32'h0456_7800, 32'hC000_0000, 32'hC123_4567, 1, 1'b0);
    run_xfer(32'h0456_7800, 32'hC000_0000, 32'hC123_4000, 8192, 1'b1);
    run_xfer(32'h0456_7800, 32'hC000_0000, 32'hC123_4000, 0, 1'b1);     // R9
    mode = 2;
    run_xfer(32'h0001_0000, 32'h8000_0000, 32'h8000_3010, 5000, 1'b0);  // R8 read ok
    run_xfer(32'h0001_0000, 32'h8000_0000, 32'h8000_3010, 5000, 1'b1);  // R8 write aborts
    mode = 3;
    run_xfer(32'h0001_0000, 32'hFE00_0000, 32'hFE00_0000, 100, 1'b0);   // R7

    for (int i = 0; i < 80; i++) begin
      logic [31:0] w;
      case ($urandom % 4)
        0: w = 32'hFF00_0000;
        1: w = 32'hFE00_0000;
        2: w = 32'hC000_0000;
        default: w = 32'h8000_0000;
      endcase
      mode = ($urandom % 2 == 0) ? 0 : 1;
      run_xfer($urandom & 32'h07FF_FC00, w, w | ($urandom & ~w),
               ($urandom % 8 == 0) ? 0 : int'($urandom % 14000), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule